// File: doc/BRIEF.md
# Receive Sampling-Delay Tuning Sequencer

This block finds a working receive sampling delay for a high-speed memory-card link. On a start request it steps a 6-bit delay tap through the usable range 0 to 39. For each tap it does three things. First it presents the tap to the delay control and requests an update twice. Then it asks the command engine to run one tuning-block transfer. Finally it records whether that transfer passed.

While it sweeps, it tracks the longest run of consecutive passing taps. At the end of the sweep it programs the tap in the middle of that run, using the same double-update procedure.

The engine serves only the fast single-data-rate mode with its matching tuning command. The caller marks that case with an eligibility input. A start request without eligibility is refused at once, so the caller can fall back to a generic tuning path.

A failed or timed-out update marks the tap as failing and skips its transfer. A sweep with no passing tap ends in an error and leaves the tap at the last swept value, with no final update issued.

Top module: `tap_sweep_tuner`

## Requirements
- R1: After reset, `busy`, `done`, `reject`, `apply_req` and `test_req` are all 0.
- R2: A `start` pulse while `eligible` is 0 gives a one-cycle `reject` pulse in the next cycle. No update and no transfer are requested, and `busy` stays 0.
- R3: An eligible `start` sweeps the taps 0, 1, ..., NUM_TAPS-1 (default 40) in ascending order. Each tap that applies correctly receives exactly one transfer request.
- R4: Every tap is applied twice. `apply_req` rises with the tap already on `tap_val` and holds both until `apply_ack` is seen. It then drops for at least one cycle before the second request, and `tap_val` does not change while `apply_req` is high.
- R5: If `apply_ack` has not arrived after APPLY_TMO cycles of `apply_req`, the request is withdrawn and the tap counts as failing. A tap whose first request times out gets no second request and no transfer.
- R6: `test_req` is raised only after both updates of the tap have completed. It is held until `test_done`, and `test_pass` is sampled with `test_done`. `apply_req` and `test_req` are never high together.
- R7: A failing tap resets the current run to zero. A pass extends the run, and the run replaces the best one only when it is strictly longer, so the earlier of two equal runs is kept.
- R8: When at least one tap passed, the final tap is the last tap of the best run minus half the run length (rounded down). It is applied with the double update, after which `done` pulses with `no_point`=0 and `apply_fail`=0, and `tap_val` holds the final tap.
- R9: When no tap passed, `done` pulses with `no_point`=1 right after the sweep, and no final update is requested.
- R10: If an update of the final tap times out, `done` pulses with `apply_fail`=1.
- R11: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run a tuning sweep |
| eligible | input | 1 | 1 when the link is in the mode and command served here |
| busy | output | 1 | Sweep or final update in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| reject | output | 1 | One-cycle pulse when start is refused |
| no_point | output | 1 | Last run found no passing tap |
| apply_fail | output | 1 | Last run's final update timed out |
| tap_val | output | 6 | Delay tap presented to the delay control |
| apply_req | output | 1 | Update request toward the delay control |
| apply_ack | input | 1 | One-cycle pulse: update completed |
| test_req | output | 1 | Tuning-block transfer request |
| test_done | input | 1 | One-cycle pulse: transfer finished |
| test_pass | input | 1 | Transfer result, valid with test_done |

## Verification
Pass maps are written across the 40 taps: all passing, none passing, a single passing tap at either end, two equal runs, a short run followed by a longer one, and alternating passes. These separate the strict-greater rule from a greater-or-equal rule, and the midpoint rounding from off-by-one errors. A delay model that withholds acknowledge for one chosen tap splits a run in two and shows that a timed-out update skips the transfer. Withholding the final update instead exercises the final-update error. Per-tap counts of update and transfer requests show the double update and the ascending order, and separate runs cover a refused start and a start repeated in mid-sweep.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_TEST,
    ST_STEP,
    ST_FINAL
  } tune_st_e;

  typedef enum logic [1:0] {
    AP_IDLE,
    AP_REQ,
    AP_GAP
  } apply_st_e;

endpackage

// File: rtl/tap_apply_ctrl.sv
// Issues two back-to-back update requests for one tap, each with a timeout.
module tap_apply_ctrl
  import tap_tune_pkg::*;
#(
  parameter int APPLY_TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic apply_ack,
  output logic apply_req,
  output logic fin,
  output logic ok
);

  localparam int TMO_W = $clog2(APPLY_TMO + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(APPLY_TMO - 1);

  apply_st_e        st_q, st_d;
  logic             second_q, second_d;
  logic [TMO_W-1:0] tmr_q, tmr_d;
  logic             fin_d, ok_d;

  always_comb begin
    st_d     = st_q;
    second_d = second_q;
    tmr_d    = tmr_q;
    fin_d    = 1'b0;
    ok_d     = ok;
    case (st_q)
      AP_IDLE: begin
        if (go) begin
          st_d     = AP_REQ;
          second_d = 1'b0;
          tmr_d    = '0;
        end
      end
      AP_REQ: begin
        if (apply_ack) begin
          tmr_d = '0;
          if (second_q) begin
            st_d  = AP_IDLE;
            fin_d = 1'b1;
            ok_d  = 1'b1;
          end else begin
            st_d = AP_GAP;
          end
        end else if (tmr_q == TMO_LAST) begin
          st_d  = AP_IDLE;
          fin_d = 1'b1;
          ok_d  = 1'b0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      AP_GAP: begin
        st_d     = AP_REQ;
        second_d = 1'b1;
        tmr_d    = '0;
      end
      default: st_d = AP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= AP_IDLE;
      second_q <= 1'b0;
      tmr_q    <= '0;
      fin      <= 1'b0;
      ok       <= 1'b0;
    end else begin
      st_q     <= st_d;
      second_q <= second_d;
      tmr_q    <= tmr_d;
      fin      <= fin_d;
      ok       <= ok_d;
    end
  end

  assign apply_req = (st_q == AP_REQ);

endmodule

// File: rtl/streak_tracker.sv
// Tracks the current and best run of passing taps and derives the run center.
module streak_tracker #(
  parameter int TAP_W    = 6,
  parameter int NUM_TAPS = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic             found,
  output logic [TAP_W-1:0] center
);

  localparam int CNT_W = $clog2(NUM_TAPS + 1);

  logic [CNT_W-1:0] cur_q, cur_d, best_q, best_d, inc;
  logic [TAP_W-1:0] end_q, end_d;

  assign inc = cur_q + CNT_W'(1);

  always_comb begin
    cur_d  = cur_q;
    best_d = best_q;
    end_d  = end_q;
    if (clr) begin
      cur_d  = '0;
      best_d = '0;
      end_d  = '0;
    end else if (upd) begin
      if (pass) begin
        cur_d = inc;
        // strictly longer only: the earlier of equal runs stays
        if (inc > best_q) begin
          best_d = inc;
          end_d  = tap;
        end
      end else begin
        cur_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else if (clr || upd) begin
      cur_q  <= cur_d;
      best_q <= best_d;
      end_q  <= end_d;
    end
  end

  assign found  = (best_q != '0);
  assign center = end_q - TAP_W'(best_q >> 1);

endmodule

// File: rtl/tap_sweep_tuner.sv
module tap_sweep_tuner
  import tap_tune_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int NUM_TAPS  = 40,
  parameter int APPLY_TMO = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             eligible,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             no_point,
  output logic             apply_fail,
  output logic [TAP_W-1:0] tap_val,
  output logic             apply_req,
  input  logic             apply_ack,
  output logic             test_req,
  input  logic             test_done,
  input  logic             test_pass
);

  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

  tune_st_e         st_q, st_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             go_q, go_d;
  logic             done_d, reject_d, np_d, af_d;
  logic             trk_clr, trk_upd, trk_pass, trk_found;
  logic [TAP_W-1:0] trk_center;
  logic             ap_fin, ap_ok;

  tap_apply_ctrl #(.APPLY_TMO(APPLY_TMO)) u_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_q),
    .apply_ack (apply_ack),
    .apply_req (apply_req),
    .fin       (ap_fin),
    .ok        (ap_ok)
  );

  streak_tracker #(.TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (trk_clr),
    .upd    (trk_upd),
    .pass   (trk_pass),
    .tap    (tap_q),
    .found  (trk_found),
    .center (trk_center)
  );

  always_comb begin
    st_d     = st_q;
    tap_d    = tap_q;
    go_d     = 1'b0;
    done_d   = 1'b0;
    reject_d = 1'b0;
    np_d     = no_point;
    af_d     = apply_fail;
    trk_clr  = 1'b0;
    trk_upd  = 1'b0;
    trk_pass = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (eligible) begin
            st_d    = ST_APPLY;
            tap_d   = '0;
            go_d    = 1'b1;
            trk_clr = 1'b1;
            np_d    = 1'b0;
            af_d    = 1'b0;
          end else begin
            reject_d = 1'b1;
          end
        end
      end
      ST_APPLY: begin
        if (ap_fin) begin
          if (ap_ok) begin
            st_d = ST_TEST;
          end else begin
            trk_upd = 1'b1;
            st_d    = ST_STEP;
          end
        end
      end
      ST_TEST: begin
        if (test_done) begin
          trk_upd  = 1'b1;
          trk_pass = test_pass;
          st_d     = ST_STEP;
        end
      end
      ST_STEP: begin
        if (tap_q == LAST_TAP) begin
          if (trk_found) begin
            tap_d = trk_center;
            go_d  = 1'b1;
            st_d  = ST_FINAL;
          end else begin
            np_d   = 1'b1;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end else begin
          tap_d = tap_q + 1'b1;
          go_d  = 1'b1;
          st_d  = ST_APPLY;
        end
      end
      ST_FINAL: begin
        if (ap_fin) begin
          af_d   = !ap_ok;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      tap_q      <= '0;
      go_q       <= 1'b0;
      done       <= 1'b0;
      reject     <= 1'b0;
      no_point   <= 1'b0;
      apply_fail <= 1'b0;
    end else begin
      st_q       <= st_d;
      tap_q      <= tap_d;
      go_q       <= go_d;
      done       <= done_d;
      reject     <= reject_d;
      no_point   <= np_d;
      apply_fail <= af_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign test_req = (st_q == ST_TEST);
  assign tap_val  = tap_q;

endmodule

// File: rtl/tap_sweep_tuner_chk.sv
module tap_sweep_tuner_chk #(
  parameter int TAP_W     = 6,
  parameter int APPLY_TMO = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             reject,
  input logic [TAP_W-1:0] tap_val,
  input logic             apply_req,
  input logic             apply_ack,
  input logic             test_req,
  input logic             test_done
);

  localparam int HC_W = $clog2(APPLY_TMO + 1) + 1;

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (apply_req) begin
      if (hi_cnt != {HC_W{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply_req && test_req));

  // R4
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_req && $past(apply_req)) |-> $stable(tap_val));

  // R4
  drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_req && apply_ack) |=> !apply_req);

  // R5
  req_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    apply_req |-> (hi_cnt < HC_W'(APPLY_TMO)));

  // R6
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> test_req);

  // R2
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && !apply_req));

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !apply_req && !test_req));

  // R1
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, reject}));

endmodule

bind tap_sweep_tuner tap_sweep_tuner_chk #(.TAP_W(TAP_W), .APPLY_TMO(APPLY_TMO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .reject    (reject),
  .tap_val   (tap_val),
  .apply_req (apply_req),
  .apply_ack (apply_ack),
  .test_req  (test_req),
  .test_done (test_done)
);

// File: tb/tap_sweep_tuner_tb.sv
`timescale 1ns/1ps
module tap_sweep_tuner_tb;

  localparam int NT = 40;

  logic       clk, rst_n, start, eligible;
  logic       busy, done, reject, no_point, apply_fail;
  logic [5:0] tap_val;
  logic       apply_req, apply_ack, test_req, test_done, test_pass;

  int n_chk, n_fail, cyc;
  logic pat [0:63];
  int   acnt [0:63];
  int   tcnt [0:63];
  int   hang_tap, adly, tdly;
  logic hang_final, hang_arm, prev_a, prev_t, order_bad;
  int   last_t;

  tap_sweep_tuner u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .eligible(eligible),
    .busy(busy), .done(done), .reject(reject), .no_point(no_point),
    .apply_fail(apply_fail), .tap_val(tap_val), .apply_req(apply_req),
    .apply_ack(apply_ack), .test_req(test_req), .test_done(test_done),
    .test_pass(test_pass)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // delay-control and command-engine models, plus request monitors
  always @(negedge clk) begin
    if (!rst_n) begin
      apply_ack = 0; test_done = 0; test_pass = 0; adly = 0; tdly = 0;
      prev_a = 0; prev_t = 0;
    end else begin
      if (apply_req && !prev_a) acnt[tap_val]++;
      if (test_req && !prev_t) begin
        tcnt[tap_val]++;
        if (last_t >= 0 && int'(tap_val) <= last_t) order_bad = 1;
        last_t = int'(tap_val);
        if (int'(tap_val) == NT - 1) hang_arm = 1;
      end
      prev_a = apply_req;
      prev_t = test_req;
      apply_ack = 0;
      if (apply_req && !(int'(tap_val) == hang_tap) && !(hang_final && hang_arm)) begin
        if (adly == 2) begin apply_ack = 1; adly = 0; end
        else adly++;
      end else adly = 0;
      test_done = 0;
      if (test_req) begin
        if (tdly == 3) begin test_done = 1; test_pass = pat[tap_val]; tdly = 0; end
        else tdly++;
      end else tdly = 0;
    end
  end

  task automatic set_pat(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) pat[i] = 1'b1;
  endtask

  task automatic clr_pat();
    for (int i = 0; i < 64; i++) pat[i] = 1'b0;
  endtask

  // full eligible run; expected values from the pass map and hang settings
  task automatic run(input string tag, input logic restart_mid);
    int cur, best, endt, ctr, n, mism;
    logic found;
    for (int i = 0; i < 64; i++) begin acnt[i] = 0; tcnt[i] = 0; end
    hang_arm = 0; order_bad = 0; last_t = -1;
    cur = 0; best = 0; endt = 0;
    for (int t = 0; t < NT; t++) begin
      if (pat[t] && t != hang_tap) begin
        cur++;
        if (cur > best) begin best = cur; endt = t; end
      end else cur = 0;
    end
    found = (best != 0);
    ctr = endt - best / 2;
    @(negedge clk); start = 1; eligible = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      if (restart_mid && n == 100) start = 1;
      if (restart_mid && n == 101) start = 0;
    end
    // R8 R9 R10
    chk(done == 1, {tag, " R8 done seen"}, done, 1);
    chk(no_point == !found, {tag, " R9 no_point"}, no_point, !found);
    chk(apply_fail == (found && hang_final), {tag, " R10 apply_fail"}, apply_fail, found && hang_final);
    if (found) chk(int'(tap_val) == ctr, {tag, " R7 R8 final tap"}, tap_val, ctr);
    mism = 0;
    for (int t = 0; t < 64; t++) begin
      int ea, et;
      ea = (t < NT) ? ((t == hang_tap) ? 1 : 2) : 0;
      et = (t < NT && t != hang_tap) ? 1 : 0;
      if (found && t == ctr) ea += hang_final ? 1 : 2;
      if (acnt[t] != ea || tcnt[t] != et) mism++;
    end
    // R3 R4 R5: per-tap update and transfer counts
    chk(mism == 0, {tag, " R3 R4 R5 per-tap request counts"}, mism, 0);
    chk(!order_bad, {tag, " R3 ascending order"}, order_bad, 0);
    @(negedge clk);
    // R11: a start during busy must not launch a second run
    chk(!busy, {tag, " R11 idle after done"}, busy, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    start = 0; eligible = 0; hang_tap = 99; hang_final = 0;
    hang_arm = 0; order_bad = 0; last_t = -1;
    clr_pat();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !reject && !apply_req && !test_req, "R1 reset state",
        {busy, done, reject, apply_req, test_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: refused start
    start = 1; eligible = 0;
    @(negedge clk); start = 0;
    chk(reject == 1, "R2 reject pulse", reject, 1);
    chk(!busy && !apply_req, "R2 no sweep", busy, 0);
    @(negedge clk);
    chk(reject == 0 && !busy && !apply_req, "R2 reject single cycle", reject, 0);

    clr_pat(); set_pat(0, NT - 1);   run("all-pass", 0);
    clr_pat();                      run("none-pass", 0);
    clr_pat(); set_pat(0, 0);       run("first-only", 0);
    clr_pat(); set_pat(39, 39);     run("last-only", 0);
    clr_pat(); set_pat(5, 9); set_pat(20, 24); run("R7 equal runs", 0);
    clr_pat(); set_pat(2, 4); set_pat(10, 17); run("R7 later longer", 0);
    clr_pat(); for (int i = 0; i < NT; i += 2) pat[i] = 1'b1; run("alternating", 0);
    clr_pat(); set_pat(30, 36);     run("odd run", 0);
    // R5: update timeout splits a run
    clr_pat(); set_pat(10, 20); hang_tap = 15; run("R5 hung tap", 0);
    hang_tap = 99;
    // R10: final update times out
    clr_pat(); set_pat(0, NT - 1); hang_final = 1; run("R10 final hang", 0);
    hang_final = 0;
    // R11: start pulsed mid-sweep
    clr_pat(); set_pat(3, 12);      run("R11 restart ignored", 1);

    finish_run();
  end

endmodule